// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block runs the transmit side of a DMA-driven Ethernet MAC. Software places 8-byte buffer descriptors in memory as a ring and then rings a doorbell. The walker starts at its current ring pointer and fetches each descriptor in turn. It collects the bytes that each descriptor points to into an internal frame buffer, then clears the descriptor's ready bit and writes the descriptor back. When a descriptor marks the end of a frame, the walker streams the collected frame out one byte per cycle.

One frame can span any number of descriptors. The total frame size is capped, and bytes beyond the cap are dropped with a babble event. A wrap bit in a descriptor sends the pointer back to the ring base. The walk stops at the first descriptor that software has not yet handed over. The pointer stays there for the next doorbell, and a frame that is not yet finished stays in the buffer.

All memory traffic goes through one 32-bit word port. Read data comes back one cycle after the request.

Top module: `tx_ring_walker`

## Requirements
- R1: A doorbell that arrives while `mac_en` is low is ignored. `busy` stays low and the ring in memory is left untouched.
- R2: A doorbell accepted while idle with `mac_en` high sets `busy` from the next cycle onward. `busy` stays high until the walk reaches a descriptor whose ready bit is clear. That descriptor is not written, and the pointer is left pointing at it.
- R3: A descriptor occupies two words. The word at the pointer holds the length in bits [15:0] and the flags in bits [31:16]: bit 31 is ready, bit 29 is wrap and bit 27 is last. The word at pointer+4 holds the byte address of the buffer. Buffer bytes are read one per request, from the byte lane chosen by address bits [1:0].
- R4: After a descriptor is consumed, the pointer moves to pointer+8. If the wrap bit is set, it moves instead to `ring_base` with bits [2:0] cleared.
- R5: Each consumed descriptor is written back to its first word with bit 31 cleared and every other bit unchanged. `ev_buf` pulses in the same cycle as that write.
- R6: A frame never holds more than FRAME_MAX (2032) bytes. A buffer that would go past the cap is cut to the space left, and `ev_babble` pulses together with that descriptor's `ev_buf`.
- R7: A descriptor with the last bit set closes the frame. `ev_frame` pulses with its write-back. The collected bytes of all the frame's descriptors then leave on `tx_data` with `tx_valid` high, in order, with `tx_last` on the final byte. After that the frame count returns to zero.
- R8: A pulse on `base_wr` while idle loads the pointer from `ring_base`. Dropping `mac_en` also reloads the pointer from `ring_base`, ends any walk, and discards a partly collected frame.
- R9: A frame left unfinished when a walk stops is kept. Bytes from the next doorbell's descriptors are appended to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_en | input | 1 | MAC enable |
| doorbell | input | 1 | Single-cycle transmit request |
| base_wr | input | 1 | Ring base was written; reload the pointer |
| ring_base | input | AW | Ring base address |
| busy | output | 1 | Walk in progress |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write (descriptor write-back) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| ev_buf | output | 1 | Descriptor consumed pulse |
| ev_frame | output | 1 | Frame closed pulse |
| ev_babble | output | 1 | Frame truncated pulse |

## Verification
The bench pushes frames that span three descriptors at odd byte addresses. A design that picked the wrong byte lane, or dropped the last byte of each buffer, would send corrupted frames. It wraps a ring back onto a descriptor it has already cleared. A walker that ignored the wrap bit, or did not stop on a cleared ready bit, would write to the wrong addresses or loop forever. It feeds 2510 bytes into one frame to force truncation, with a zero-room descriptor after the cap is reached; a wrong cap would give the wrong length or miss the babble events. Finally it leaves frames half built and then continues them or disables the MAC. Losing the partial bytes, or keeping them after a disable, shows up directly in the emitted byte stream.

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int AW        = 32,
  parameter int FRAME_MAX = 2032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mac_en,
  input  logic          doorbell,
  input  logic          base_wr,
  input  logic [AW-1:0] ring_base,
  output logic          busy,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          ev_buf,
  output logic          ev_frame,
  output logic          ev_babble
);
  localparam int LW = $clog2(FRAME_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_D0, S_D1, S_D2, S_GATH, S_WB, S_EMIT} st_t;
  st_t state;

  logic [AW-1:0] ptr, bufa;
  logic [31:0]   w0;
  logic [LW-1:0] acc, cnt, take, oidx;
  logic          trunc, pend;
  logic [1:0]    lane;
  logic [7:0]    fbuf [FRAME_MAX];

  wire [AW-1:0] base_al   = ring_base & ~AW'(7);
  wire [LW-1:0] room      = LW'(FRAME_MAX) - acc;
  wire          too_long  = {16'b0, w0[15:0]} > 32'(room);
  wire          want_w1   = (state == S_D1) && mem_rdata[31];
  wire          gath_rd   = (state == S_GATH) && (cnt != take);

  assign busy      = state != S_IDLE;
  assign mem_rd_en = (state == S_D0) || want_w1 || gath_rd;
  assign mem_wr_en = state == S_WB;
  assign mem_wdata = {1'b0, w0[30:0]};
  assign ev_buf    = state == S_WB;
  assign ev_babble = ev_buf && trunc;
  assign ev_frame  = ev_buf && w0[27];
  assign tx_valid  = state == S_EMIT;
  assign tx_data   = fbuf[oidx];
  assign tx_last   = tx_valid && (oidx == acc - LW'(1));

  always_comb begin
    case (state)
      S_D1:    mem_addr = ptr + AW'(4);
      S_GATH:  mem_addr = bufa + AW'(cnt);
      default: mem_addr = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (state == S_GATH && pend) fbuf[acc] <= mem_rdata[{lane, 3'b000} +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr   <= '0;
      bufa  <= '0;
      w0    <= '0;
      acc   <= '0;
      cnt   <= '0;
      take  <= '0;
      oidx  <= '0;
      trunc <= 1'b0;
      pend  <= 1'b0;
      lane  <= '0;
    end else if (!mac_en) begin
      state <= S_IDLE;
      ptr   <= base_al;
      acc   <= '0;
      pend  <= 1'b0;
    end else begin
      if (base_wr) ptr <= base_al;
      pend <= gath_rd;
      lane <= mem_addr[1:0];
      case (state)
        S_IDLE: if (doorbell) state <= S_D0;
        S_D0:   state <= S_D1;
        S_D1: begin
          w0    <= mem_rdata;
          state <= mem_rdata[31] ? S_D2 : S_IDLE;
        end
        S_D2: begin
          bufa  <= mem_rdata[AW-1:0];
          trunc <= too_long;
          take  <= too_long ? room : LW'(w0[15:0]);
          cnt   <= '0;
          state <= S_GATH;
        end
        S_GATH: begin
          if (gath_rd) cnt <= cnt + LW'(1);
          if (pend) acc <= acc + LW'(1);
          if (!gath_rd && !pend) state <= S_WB;
        end
        S_WB: begin
          ptr  <= w0[29] ? base_al : ptr + AW'(8);
          oidx <= '0;
          if (w0[27] && acc != '0) state <= S_EMIT;
          else                     state <= S_D0;
        end
        S_EMIT: begin
          oidx <= oidx + LW'(1);
          if (oidx == acc - LW'(1)) begin
            acc   <= '0;
            state <= S_D0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ignore_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && doorbell && !mac_en) |=> !busy);
  assert_accept_doorbell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && doorbell && mac_en) |=> busy);
  assert_single_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  assert_wb_clears_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !mem_wdata[31] && ev_buf);
  assert_babble_with_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_babble |-> mem_wr_en);
  assert_frame_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (32'(acc) <= FRAME_MAX));
  assert_frame_with_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |-> mem_wr_en);
  assert_disable_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_en |=> !busy && !tx_valid);
endmodule

// File: tb/tx_ring_walker_tb.sv
`timescale 1ns/1ps
module tx_ring_walker_tb_top;
  localparam logic [15:0] RDY = 16'h8000, WRP = 16'h2000, LST = 16'h0800;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, mac_en = 1'b0, doorbell = 1'b0, base_wr = 1'b0;
  logic [31:0] ring_base = '0;
  logic busy, mem_rd_en, mem_wr_en, tx_valid, tx_last, ev_buf, ev_frame, ev_babble;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;

  tx_ring_walker dut_i (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .doorbell(doorbell), .base_wr(base_wr),
    .ring_base(ring_base), .busy(busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_babble(ev_babble));

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_wr_en) mem[mem_addr[11:2]] <= mem_wdata;
  end

  logic [8:0]  exp_tx [$];
  logic [63:0] exp_wb [$];
  logic [1:0]  exp_ev [$];
  logic [7:0]  m_frame [$];
  int m_ptr = 0, m_acc = 0, base_reg = 0;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [63:0] e;
    if (rst_n) begin
      if (tx_valid) begin
        if (exp_tx.size() == 0) chk(0, "R7", "unexpected tx byte", {tx_last, tx_data}, 0);
        else begin
          e = 64'(exp_tx.pop_front());
          chk({tx_last, tx_data} == e[8:0], "R7", "tx byte/last (R3 lanes, R9 carry)", {tx_last, tx_data}, e);
        end
      end
      if (mem_wr_en) begin
        if (exp_wb.size() == 0) chk(0, "R5", "unexpected write-back", {mem_addr, mem_wdata}, 0);
        else begin
          e = exp_wb.pop_front();
          chk({mem_addr, mem_wdata} == e, "R5", "write-back addr/data (R4 pointer)", {mem_addr, mem_wdata}, e);
        end
      end
      if (ev_buf || ev_frame || ev_babble) begin
        if (!ev_buf) chk(0, "R5", "event without ev_buf", {ev_babble, ev_frame}, 0);
        else if (exp_ev.size() == 0) chk(0, "R5", "unexpected ev_buf", 1, 0);
        else begin
          e = 64'(exp_ev.pop_front());
          chk({ev_babble, ev_frame} == e[1:0], "R6", "babble/frame events", {ev_babble, ev_frame}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic put_desc(input int a, input int len, input logic [15:0] fl, input int ba);
    mem[a >> 2]       = {fl, 16'(len)};
    mem[(a >> 2) + 1] = 32'(ba);
  endtask

  task automatic model_walk();
    bit clr [int];
    for (int n = 0; n < 64; n++) begin
      logic [31:0] w, d;
      int len, ba, room, take;
      w = mem[m_ptr >> 2];
      if (!w[31] || clr.exists(m_ptr)) break;
      clr[m_ptr] = 1'b1;
      len  = int'(w[15:0]);
      ba   = int'(mem[(m_ptr >> 2) + 1]);
      room = 2032 - m_acc;
      take = (len > room) ? room : len;
      for (int i = 0; i < take; i++) begin
        d = mem[(ba + i) >> 2];
        m_frame.push_back(d[8 * ((ba + i) & 3) +: 8]);
      end
      m_acc += take;
      exp_wb.push_back({32'(m_ptr), w & 32'h7fff_ffff});
      exp_ev.push_back({len > room, w[27]});
      if (w[27]) begin
        for (int i = 0; i < m_frame.size(); i++)
          exp_tx.push_back({i == m_frame.size() - 1, m_frame[i]});
        m_frame.delete();
        m_acc = 0;
      end
      m_ptr = w[29] ? base_reg : m_ptr + 8;
    end
  endtask

  task automatic ring(input bit accept);
    if (accept) model_walk();
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
    chk(busy == accept, accept ? "R2" : "R1", "busy after doorbell", busy, accept);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_tx.size() == 0 && exp_wb.size() == 0 && exp_ev.size() == 0, "R2",
        "walk ended with all expected traffic seen", exp_tx.size() + exp_wb.size(), 0);
  endtask

  task automatic set_base(input int a);
    @(negedge clk) begin ring_base = 32'(a); base_wr = 1'b1; end
    @(negedge clk) base_wr = 1'b0;
    base_reg = a & ~7;
    m_ptr    = base_reg;
  endtask

  task automatic mac_cycle();
    @(negedge clk) mac_en = 1'b0;
    @(negedge clk);
    chk(!busy && !tx_valid, "R8", "idle while disabled", busy, 0);
    m_acc = 0; m_frame.delete(); m_ptr = base_reg;
    @(negedge clk) mac_en = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i < 256) ? 32'h0 : 32'(i) * 32'h9E37_79B1;
    repeat (4) @(negedge clk);
    chk(!busy && !tx_valid && !mem_wr_en && !mem_rd_en, "R2", "reset state idle",
        {busy, tx_valid, mem_wr_en, mem_rd_en}, 0);
    rst_n = 1'b1; mac_en = 1'b1;

    // R3 R7: single descriptor frame
    set_base(32'h100);
    put_desc(32'h100, 5, RDY | LST, 32'h400);
    ring(1);
    // R7: frame across three descriptors at odd byte addresses
    put_desc(32'h108, 3, RDY, 32'h501);
    put_desc(32'h110, 7, RDY, 32'h602);
    put_desc(32'h118, 2, RDY | LST, 32'h703);
    ring(1);
    // R9: partial frame carried across doorbells
    put_desc(32'h120, 4, RDY, 32'h455);
    ring(1);
    put_desc(32'h128, 6, RDY | LST, 32'h811);
    ring(1);
    chk(mem[32'h128 >> 2][31] == 1'b0, "R9", "continuation descriptor consumed", mem[32'h128 >> 2], 0);
    // R4: wrap back to base, stop on already cleared descriptor
    set_base(32'h200);
    put_desc(32'h200, 3, RDY, 32'h480);
    put_desc(32'h208, 4, RDY | WRP | LST, 32'h4a1);
    ring(1);
    put_desc(32'h200, 2, RDY | LST, 32'h4c2);
    ring(1);
    // R6: cap at 2032 bytes, zero-room descriptor still babbles
    set_base(32'h280);
    put_desc(32'h280, 1500, RDY, 32'h400);
    put_desc(32'h288, 1000, RDY, 32'h400);
    put_desc(32'h290, 10, RDY | LST, 32'h400);
    ring(1);
    put_desc(32'h298, 3, RDY | LST, 32'h433);
    ring(1);
    // R1: doorbell ignored while disabled; R8 pointer reload on disable
    put_desc(32'h280, 2, RDY | LST, 32'h477);
    put_desc(32'h2a0, 2, RDY | LST, 32'h477);
    @(negedge clk) mac_en = 1'b0;
    ring(0);
    chk(mem[32'h280 >> 2][31] && mem[32'h2a0 >> 2][31], "R1", "ring untouched while disabled",
        {mem[32'h280 >> 2][31], mem[32'h2a0 >> 2][31]}, 2'b11);
    m_ptr = base_reg;
    @(negedge clk) mac_en = 1'b1;
    ring(1);
    // R8: partial frame dropped by disable
    set_base(32'h300);
    put_desc(32'h300, 5, RDY, 32'h900);
    ring(1);
    mac_cycle();
    put_desc(32'h300, 3, RDY | LST, 32'ha00);
    ring(1);
    // R8: base write reloads pointer
    set_base(32'h340);
    put_desc(32'h340, 1, RDY | LST, 32'h9f1);
    ring(1);
    // R2: first descriptor not ready
    ring(1);
    chk(mem[32'h348 >> 2] == 32'h0, "R2", "not-ready descriptor left alone", mem[32'h348 >> 2], 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule